// File: doc/BRIEF.md
# Adaptive Update/Invalidate Coherence Directory

This block sits inside one shared-memory bank and keeps a full bit-vector directory for the blocks held in that bank. Each core's view of a block is tracked as one of four states. The fourth state marks a copy that was valid and was then killed by another core's write. The caches write through and never allocate on a write miss, so every write and every read miss reaches the directory. The directory changes its entries in the same cycle that it accepts a request.

Each block carries its own protocol bit, write counter and update-threshold counter. When a killed copy is read again soon after it was invalidated, the block switches to update mode for a number of writes. If the re-read comes only after a long run of writes, the allowance for update mode shrinks. Coherence traffic leaves on a separate one-way bus with a single message slot. While that slot is full, new requests are stalled.

The request port is valid/ready: a request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a coherence message is waiting for `cb_ready`. The coherence bus is valid/ready: a message stays on the bus without change until `cb_ready` is seen high. Read responses and the query port are plain signals.

Top module: `hyb_coh_dir`

## Requirements
- R1: After reset every per-core state is Invalid, every block is in invalidate mode with both counters at 0, `req_ready` is 1, and `rsp_valid` and `cb_valid` are 0. State codes on `q_states` are Invalid=0, Shared=1, Exclusive=2, Other-invalidated=3, with core i in bits [2i+1:2i].
- R2: On a read miss, the requester becomes Exclusive if no other core is Exclusive or Shared. Otherwise the requester becomes Shared, any Exclusive holder drops to Shared, and `rsp_shared` is 1.
- R3: A write to a block in invalidate mode moves every other Exclusive or Shared core to Other-invalidated, and a writer that held the block becomes Exclusive. It sends one invalidate message (`cb_update`=0) whose `cb_mask` names exactly those cores, and it raises W by one, saturating at its maximum.
- R4: A write to a block in update mode sends one update message (`cb_update`=1) carrying the write data to the Exclusive and Shared cores other than the writer. It leaves all states unchanged and lowers W by one. When W reaches 0, the block returns to invalidate mode.
- R5: A write whose target set is empty sends no message.
- R6: A read miss by an Other-invalidated core on a block in invalidate mode with W below DELTA (default 1000) raises UC by one with saturation, sets update mode, and loads W with the new UC.
- R7: The same read miss with W at or above DELTA lowers UC by one, saturating at 0. It clears W and keeps invalidate mode.
- R8: While `cb_valid` is high and `cb_ready` is low, the message fields stay stable and `req_ready` is 0.
- R9: `rsp_valid` pulses for exactly the cycle after a read is accepted and carries that read's core. `cb_valid` rises in the cycle after an accepted write that has targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read miss |
| req_core | input | $clog2(NCORES) | Requesting core |
| req_block | input | $clog2(NBLOCKS) | Block index within the bank |
| req_data | input | DW | Write data |
| rsp_valid | output | 1 | Read response pulse |
| rsp_core | output | $clog2(NCORES) | Core being answered |
| rsp_shared | output | 1 | 1 = granted Shared, 0 = granted Exclusive |
| cb_valid | output | 1 | Coherence message present |
| cb_ready | input | 1 | Caches take the message |
| cb_update | output | 1 | 1 = update, 0 = invalidate |
| cb_block | output | $clog2(NBLOCKS) | Block of the message |
| cb_mask | output | NCORES | Target cores |
| cb_data | output | DW | Write data for update messages |
| q_block | input | $clog2(NBLOCKS) | Block to inspect |
| q_states | output | 2*NCORES | Per-core states of that block |
| q_mode | output | 1 | Protocol bit, 1 = update |
| q_wcnt | output | CNT_W | Write counter |
| q_ucnt | output | CNT_W | Update-threshold counter |

## Verification
A request is accepted on a rising edge. The directory entry, and so the query port, shows its new value right after that edge. The read response and any coherence message appear in the cycle that follows. The bench drives at falling edges and reads the query port a moment after the falling edge that follows acceptance. A scoreboard queue holds the expected responses and messages, and a monitor compares them at every falling edge where a response is valid or a message is handed over. The stall test holds `cb_ready` low and checks that the message stays stable and `req_ready` stays low. The threshold tests run long write strings so that W lands at 999, 1000 and 1001.

// File: rtl/hyb_coh_pkg.sv
package hyb_coh_pkg;
  typedef enum logic [1:0] {
    ST_INV   = 2'd0,
    ST_SHR   = 2'd1,
    ST_EXCL  = 2'd2,
    ST_OTHER = 2'd3
  } cstate_e;
endpackage

// File: rtl/hyb_sharer_next.sv
module hyb_sharer_next
  import hyb_coh_pkg::*;
#(
  parameter int NCORES = 4,
  localparam int CIW = $clog2(NCORES)
) (
  input  logic [2*NCORES-1:0] st_i,
  input  logic [CIW-1:0]      core_i,
  input  logic                write_i,
  input  logic                upd_mode_i,
  output logic [2*NCORES-1:0] st_o,
  output logic [NCORES-1:0]   targets_o,
  output logic                shared_o
);
  logic [NCORES-1:0] holds;

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    logic [1:0] cur;
    logic       self;
    assign cur       = st_i[2*i +: 2];
    assign self      = (core_i == CIW'(i));
    assign holds[i]  = (cur == ST_EXCL) || (cur == ST_SHR);
    assign targets_o[i] = holds[i] && !self;

    always_comb begin
      st_o[2*i +: 2] = cur;
      if (write_i) begin
        if (!upd_mode_i) begin
          if (self && holds[i])        st_o[2*i +: 2] = ST_EXCL;
          else if (!self && holds[i])  st_o[2*i +: 2] = ST_OTHER;
        end
      end else begin
        if (self)                      st_o[2*i +: 2] = shared_o ? ST_SHR : ST_EXCL;
        else if (cur == ST_EXCL)       st_o[2*i +: 2] = ST_SHR;
      end
    end
  end

  assign shared_o = |targets_o;
endmodule

// File: rtl/hyb_mode_engine.sv
module hyb_mode_engine #(
  parameter int CNT_W = 11,
  parameter int DELTA = 1000
) (
  input  logic             p_i,
  input  logic [CNT_W-1:0] w_i,
  input  logic [CNT_W-1:0] uc_i,
  input  logic             write_i,
  input  logic             omiss_i,
  output logic             p_o,
  output logic [CNT_W-1:0] w_o,
  output logic [CNT_W-1:0] uc_o
);
  localparam logic [CNT_W-1:0] MAXV  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELTA);

  logic [CNT_W-1:0] uc_up;
  assign uc_up = (uc_i == MAXV) ? uc_i : uc_i + 1'b1;

  always_comb begin
    p_o  = p_i;
    w_o  = w_i;
    uc_o = uc_i;
    if (write_i) begin
      if (p_i) begin
        w_o = (w_i == '0) ? w_i : w_i - 1'b1;
        if (w_i <= CNT_W'(1)) p_o = 1'b0;
      end else begin
        w_o = (w_i == MAXV) ? w_i : w_i + 1'b1;
      end
    end else if (omiss_i && !p_i) begin
      if (w_i < LIMIT) begin
        uc_o = uc_up;
        w_o  = uc_up;
        p_o  = 1'b1;
      end else begin
        uc_o = (uc_i == '0) ? uc_i : uc_i - 1'b1;
        w_o  = '0;
      end
    end
  end
endmodule

// File: rtl/hyb_coh_tx.sv
module hyb_coh_tx #(
  parameter int NCORES  = 4,
  parameter int NBLOCKS = 16,
  parameter int DW      = 32,
  localparam int BIW = $clog2(NBLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              upd_i,
  input  logic [BIW-1:0]    blk_i,
  input  logic [NCORES-1:0] mask_i,
  input  logic [DW-1:0]     data_i,
  input  logic              cb_ready,
  output logic              cb_valid,
  output logic              cb_update,
  output logic [BIW-1:0]    cb_block,
  output logic [NCORES-1:0] cb_mask,
  output logic [DW-1:0]     cb_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cb_valid  <= 1'b0;
      cb_update <= 1'b0;
      cb_block  <= '0;
      cb_mask   <= '0;
      cb_data   <= '0;
    end else if (load_i) begin
      cb_valid  <= 1'b1;
      cb_update <= upd_i;
      cb_block  <= blk_i;
      cb_mask   <= mask_i;
      cb_data   <= data_i;
    end else if (cb_valid && cb_ready) begin
      cb_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/hyb_coh_dir.sv
module hyb_coh_dir
  import hyb_coh_pkg::*;
#(
  parameter int NCORES  = 4,
  parameter int NBLOCKS = 16,
  parameter int DW      = 32,
  parameter int CNT_W   = 11,
  parameter int DELTA   = 1000,
  localparam int CIW = $clog2(NCORES),
  localparam int BIW = $clog2(NBLOCKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [CIW-1:0]      req_core,
  input  logic [BIW-1:0]      req_block,
  input  logic [DW-1:0]       req_data,
  output logic                rsp_valid,
  output logic [CIW-1:0]      rsp_core,
  output logic                rsp_shared,
  output logic                cb_valid,
  input  logic                cb_ready,
  output logic                cb_update,
  output logic [BIW-1:0]      cb_block,
  output logic [NCORES-1:0]   cb_mask,
  output logic [DW-1:0]       cb_data,
  input  logic [BIW-1:0]      q_block,
  output logic [2*NCORES-1:0] q_states,
  output logic                q_mode,
  output logic [CNT_W-1:0]    q_wcnt,
  output logic [CNT_W-1:0]    q_ucnt
);
  logic [2*NCORES-1:0] st_q [NBLOCKS];
  logic                p_q  [NBLOCKS];
  logic [CNT_W-1:0]    w_q  [NBLOCKS];
  logic [CNT_W-1:0]    uc_q [NBLOCKS];

  logic                accept;
  logic [2*NCORES-1:0] cur_st, nxt_st;
  logic                cur_p, nxt_p;
  logic [CNT_W-1:0]    cur_w, nxt_w, cur_uc, nxt_uc;
  logic [NCORES-1:0]   targets;
  logic                shared;
  logic                omiss;

  assign req_ready = !cb_valid;
  assign accept    = req_valid && req_ready;

  assign cur_st = st_q[req_block];
  assign cur_p  = p_q[req_block];
  assign cur_w  = w_q[req_block];
  assign cur_uc = uc_q[req_block];
  assign omiss  = !req_write && (cur_st[2*req_core +: 2] == ST_OTHER);

  hyb_sharer_next #(.NCORES(NCORES)) u_share (
    .st_i(cur_st), .core_i(req_core), .write_i(req_write), .upd_mode_i(cur_p),
    .st_o(nxt_st), .targets_o(targets), .shared_o(shared)
  );

  hyb_mode_engine #(.CNT_W(CNT_W), .DELTA(DELTA)) u_mode (
    .p_i(cur_p), .w_i(cur_w), .uc_i(cur_uc), .write_i(req_write), .omiss_i(omiss),
    .p_o(nxt_p), .w_o(nxt_w), .uc_o(nxt_uc)
  );

  hyb_coh_tx #(.NCORES(NCORES), .NBLOCKS(NBLOCKS), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load_i(accept && req_write && (|targets)), .upd_i(cur_p),
    .blk_i(req_block), .mask_i(targets), .data_i(req_data),
    .cb_ready(cb_ready), .cb_valid(cb_valid), .cb_update(cb_update),
    .cb_block(cb_block), .cb_mask(cb_mask), .cb_data(cb_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLOCKS; b++) begin
        st_q[b] <= '0;
        p_q[b]  <= 1'b0;
        w_q[b]  <= '0;
        uc_q[b] <= '0;
      end
    end else if (accept) begin
      st_q[req_block] <= nxt_st;
      p_q[req_block]  <= nxt_p;
      w_q[req_block]  <= nxt_w;
      uc_q[req_block] <= nxt_uc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_core   <= '0;
      rsp_shared <= 1'b0;
    end else begin
      rsp_valid  <= accept && !req_write;
      rsp_core   <= req_core;
      rsp_shared <= shared;
    end
  end

  assign q_states = st_q[q_block];
  assign q_mode   = p_q[q_block];
  assign q_wcnt   = w_q[q_block];
  assign q_ucnt   = uc_q[q_block];
endmodule

// File: rtl/hyb_coh_dir_chk.sv
module hyb_coh_dir_chk #(
  parameter int NCORES  = 4,
  parameter int NBLOCKS = 16,
  parameter int DW      = 32,
  localparam int CIW = $clog2(NCORES),
  localparam int BIW = $clog2(NBLOCKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [CIW-1:0]    req_core,
  input logic              rsp_valid,
  input logic [CIW-1:0]    rsp_core,
  input logic              cb_valid,
  input logic              cb_ready,
  input logic              cb_update,
  input logic [BIW-1:0]    cb_block,
  input logic [NCORES-1:0] cb_mask,
  input logic [DW-1:0]     cb_data
);
  p_msg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cb_valid && !cb_ready |=> cb_valid && $stable(cb_mask) && $stable(cb_block)
                              && $stable(cb_update) && $stable(cb_data));

  p_mask_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cb_valid |-> cb_mask != '0);

  p_rsp_due_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid && rsp_core == $past(req_core));

  p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);

  p_no_self_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> !(cb_valid && cb_mask[$past(req_core)]));
endmodule

bind hyb_coh_dir hyb_coh_dir_chk #(.NCORES(NCORES), .NBLOCKS(NBLOCKS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_core(req_core), .rsp_valid(rsp_valid), .rsp_core(rsp_core),
  .cb_valid(cb_valid), .cb_ready(cb_ready), .cb_update(cb_update), .cb_block(cb_block),
  .cb_mask(cb_mask), .cb_data(cb_data)
);

// File: tb/hyb_coh_dir_test.sv
`timescale 1ns/1ps
module hyb_coh_dir_test;
  localparam int NC = 4, NB = 16, DW = 32, CW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, cb_ready = 1'b1;
  logic [1:0] req_core = '0;
  logic [3:0] req_block = '0, q_block = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, rsp_valid, rsp_shared, cb_valid, cb_update, q_mode;
  logic [1:0] rsp_core;
  logic [3:0] cb_block, cb_mask;
  logic [DW-1:0] cb_data;
  logic [2*NC-1:0] q_states;
  logic [CW-1:0] q_wcnt, q_ucnt;

  int checks = 0, fails = 0;
  logic [7:0]  rsp_exp [$];
  logic [63:0] cb_exp  [$];

  always #2.5 clk = ~clk;

  hyb_coh_dir uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_core(req_core), .req_block(req_block), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_shared(rsp_shared),
    .cb_valid(cb_valid), .cb_ready(cb_ready), .cb_update(cb_update), .cb_block(cb_block),
    .cb_mask(cb_mask), .cb_data(cb_data), .q_block(q_block), .q_states(q_states),
    .q_mode(q_mode), .q_wcnt(q_wcnt), .q_ucnt(q_ucnt)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_cb(logic upd, logic [3:0] blk, logic [3:0] m, logic [31:0] d);
    return {23'd0, upd, blk, m, (upd ? d : 32'd0)};
  endfunction

  // Monitor: compares results against the scoreboard at falling edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (rsp_exp.size() == 0) chk("R9 unexpected response", {rsp_core, rsp_shared}, 0);
        else chk("R2/R9 read response", {61'd0, rsp_core, rsp_shared}, {56'd0, rsp_exp.pop_front()});
      end
      if (cb_valid && cb_ready) begin
        if (cb_exp.size() == 0) chk("R5 unexpected message", {cb_update, cb_block, cb_mask}, 0);
        else chk("R3/R4 coherence message", pack_cb(cb_update, cb_block, cb_mask, cb_data),
                 cb_exp.pop_front());
      end
    end
  end

  task automatic send(input logic wr, input int core, input int blk, input logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_core = 2'(core); req_block = 4'(blk); req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input int core, input int blk, input logic shr);
    rsp_exp.push_back({5'd0, 2'(core), shr});
    send(1'b0, core, blk, '0);
  endtask

  task automatic qchk(input string tag, input int blk, input logic [7:0] st,
                      input logic p, input int w, input int uc);
    q_block = 4'(blk);
    #0.5;
    chk({tag, " states"}, {56'd0, q_states}, {56'd0, st});
    chk({tag, " mode"}, {63'd0, q_mode}, {63'd0, p});
    chk({tag, " W"}, {53'd0, q_wcnt}, 64'(w));
    chk({tag, " UC"}, {53'd0, q_ucnt}, 64'(uc));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 req_ready", {63'd0, req_ready}, 1);
    chk("R1 cb_valid", {63'd0, cb_valid}, 0);
    chk("R1 rsp_valid", {63'd0, rsp_valid}, 0);
    qchk("R1 block0", 0, 8'h00, 0, 0, 0);

    // R2: first reader exclusive, second reader shares and demotes
    rd(0, 1, 1'b0);
    qchk("R2 excl", 1, 8'h02, 0, 0, 0);
    rd(1, 1, 1'b1);
    qchk("R2 demote", 1, 8'h05, 0, 0, 0);

    // R3 and R8: invalidate with stalled bus
    cb_ready = 1'b0;
    cb_exp.push_back(pack_cb(1'b0, 4'd1, 4'b0011, '0));
    send(1'b1, 2, 1, 32'h1111_0000);
    chk("R9 cb_valid due", {63'd0, cb_valid}, 1);
    chk("R8 stall ready", {63'd0, req_ready}, 0);
    repeat (2) @(negedge clk);
    chk("R8 hold valid", {63'd0, cb_valid}, 1);
    chk("R8 hold mask", {60'd0, cb_mask}, 4'b0011);
    chk("R8 stall ready later", {63'd0, req_ready}, 0);
    @(posedge clk); #1 cb_ready = 1'b1;
    @(negedge clk);
    qchk("R3 inv", 1, 8'h0F, 0, 1, 0);

    // R6: quick re-read switches to update mode
    rd(0, 1, 1'b0);
    qchk("R6 to update", 1, 8'h0E, 1, 1, 1);

    // R4: update write, W reaches 0
    cb_exp.push_back(pack_cb(1'b1, 4'd1, 4'b0001, 32'hA5A5_0001));
    send(1'b1, 3, 1, 32'hA5A5_0001);
    qchk("R4 back to inv", 1, 8'h0E, 0, 0, 1);

    // R6: second quick re-read, UC grows to 2
    rd(1, 1, 1'b1);
    qchk("R6 grow", 1, 8'h05, 1, 2, 2);
    cb_exp.push_back(pack_cb(1'b1, 4'd1, 4'b0011, 32'hBEEF_0002));
    send(1'b1, 2, 1, 32'hBEEF_0002);
    qchk("R4 count down", 1, 8'h05, 1, 1, 2);
    cb_exp.push_back(pack_cb(1'b1, 4'd1, 4'b0011, 32'hBEEF_0003));
    send(1'b1, 2, 1, 32'hBEEF_0003);
    qchk("R4 exhausted", 1, 8'h05, 0, 0, 2);
    cb_exp.push_back(pack_cb(1'b0, 4'd1, 4'b0011, '0));
    send(1'b1, 2, 1, 32'h0);
    // R5: writes with no holders send nothing
    for (int k = 0; k < 1000; k++) send(1'b1, 2, 1, 32'(k));
    qchk("R5 no msgs W", 1, 8'h0F, 0, 1001, 2);

    // R7: distant re-read shrinks UC
    rd(0, 1, 1'b0);
    qchk("R7 shrink", 1, 8'h0E, 0, 0, 1);

    // R6 boundary: W = 999
    rd(0, 3, 1'b0);
    cb_exp.push_back(pack_cb(1'b0, 4'd3, 4'b0001, '0));
    send(1'b1, 1, 3, 32'h0);
    for (int k = 0; k < 998; k++) send(1'b1, 1, 3, 32'(k));
    qchk("R3 W 999", 3, 8'h03, 0, 999, 0);
    rd(0, 3, 1'b0);
    qchk("R6 below delta", 3, 8'h02, 1, 1, 1);

    // R7 boundary: W = 1000, UC saturates at 0
    rd(0, 2, 1'b0);
    cb_exp.push_back(pack_cb(1'b0, 4'd2, 4'b0001, '0));
    send(1'b1, 1, 2, 32'h0);
    for (int k = 0; k < 999; k++) send(1'b1, 1, 2, 32'(k));
    rd(0, 2, 1'b0);
    qchk("R7 at delta", 2, 8'h02, 0, 0, 0);

    // R3: writer holding a shared copy becomes exclusive
    rd(0, 4, 1'b0);
    rd(1, 4, 1'b1);
    cb_exp.push_back(pack_cb(1'b0, 4'd4, 4'b0010, '0));
    send(1'b1, 0, 4, 32'h0);
    qchk("R3 writer excl", 4, 8'h0E, 0, 1, 0);

    repeat (3) @(negedge clk);
    chk("R9 responses drained", 64'(rsp_exp.size()), 0);
    chk("R3 messages drained", 64'(cb_exp.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule